// File: doc/BRIEF.md
# Dual-Mode Timer/Counter Unit

This block is an 8-bit timer/counter built from two count bytes, a low byte and a high byte, plus two overflow flags. In reload mode only the low byte counts. Each time it wraps past its all-ones value it is reloaded from the high byte, which acts as a software-set period value, and the primary flag is raised. In split mode the two bytes are independent counters. The low byte keeps the primary controls and flag. The high byte counts timer ticks under a second run bit and raises a second flag.

Counting is paced by a peripheral tick (a one-cycle clock enable) or by falling edges on an external count pin, which are resynchronised into the core clock. An active-low gate pin can further qualify the low byte. Software loads the control register, the count bytes and the flags through write strobes. An interrupt controller acknowledges each flag with a strobe.

Top module: `dual_timer_unit`

## Requirements
- R1: In reload mode (control bit 4 = 0), when the low byte increments from 0xFF it takes the current high-byte value and the primary flag is set in the same edge.
- R2: In reload mode the high byte changes only on a high-byte write. A value written to it is used by the next low-byte wrap.
- R3: `ack_a_i` clears the primary flag and `ack_b_i` clears the second flag one edge later.
- R4: Control bit 2 picks the low-byte source: 0 counts cycles with `tick_i` high, 1 counts falling edges of `cnt_pin_i`. The pin passes two synchronising flops, and a fall counts in the first cycle with `tick_i` high after it reaches the second flop. At most one count is made per tick.
- R5: The low byte counts only while control bit 0 (run A) is set. When control bit 3 (gate) is set, it also needs `gate_ni` low after two synchronising flops.
- R6: In split mode (control bit 4 = 1) the low byte uses the same source, run and gate rules, wraps from 0xFF to 0x00 and sets the primary flag.
- R7: In split mode the high byte counts every cycle with `tick_i` high while control bit 1 (run B) is set. It ignores the source and gate bits, and it sets the second flag when it wraps from 0xFF to 0x00.
- R8: In reload mode the high byte never counts and hardware never sets the second flag, whatever run B holds.
- R9: A flag write sets the flag to the written bit and wins over a same-cycle hardware set. A hardware set wins over a same-cycle acknowledge.
- R10: A byte write loads `wdata_i` and overrides that byte's increment or reload in the same cycle. No overflow flag is set by that cycle.
- R11: After reset both bytes read 0x00, both flags are low and all control bits are zero, so nothing counts.
- R12: `ctl_we_i` loads the control register from `ctl_wdata_i` with run A at bit 0, run B at bit 1, source select at bit 2, gate at bit 3 and mode at bit 4. The new value governs counting from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Peripheral timer tick, one-cycle enable |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| gate_ni | input | 1 | External active-low gate pin, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 5 | Control register write data |
| lo_we_i | input | 1 | Low byte write strobe |
| hi_we_i | input | 1 | High byte write strobe |
| wdata_i | input | 8 | Byte write data |
| flag_a_we_i | input | 1 | Primary flag write strobe |
| flag_a_wdata_i | input | 1 | Primary flag write value |
| flag_b_we_i | input | 1 | Second flag write strobe |
| flag_b_wdata_i | input | 1 | Second flag write value |
| ack_a_i | input | 1 | Primary flag acknowledge |
| ack_b_i | input | 1 | Second flag acknowledge |
| lo_o | output | 8 | Low count byte |
| hi_o | output | 8 | High count byte |
| flag_a_o | output | 1 | Primary overflow flag |
| flag_b_o | output | 1 | Second overflow flag |

## Verification
The properties assume that software writes are one-cycle strobes. They also assume that a flag write, a byte write or an acknowledge may coincide with hardware activity, and they exclude those cases explicitly rather than asking the stimulus to avoid them. The pins are taken as asynchronous, so no property relates them to the count directly. Only the synchronised event reaches the checks. The stimulus changes pins and strobes half a cycle away from the active edge, holds the count pin at each level for several cycles so that every fall is seen, and deliberately lines up flag writes and acknowledges with wraps to exercise the priorities.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic split;    // bit 4: 0 reload mode, 1 split mode
    logic gate;     // bit 3: gate pin qualifies low byte
    logic src_ext;  // bit 2: 0 tick, 1 external pin falls
    logic run_b;    // bit 1: high byte run in split mode
    logic run_a;    // bit 0: low byte run
  } dtu_ctl_t;
endpackage

// File: rtl/dtu_sync.sv
module dtu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dtu_fall_event.sv
module dtu_fall_event #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic evt_o
);
  logic pin_s;
  logic seen_q, seen_d;

  dtu_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // level last seen at a tick; a fall counts once per tick
  always_comb begin
    seen_d = seen_q;
    if (tick_i) seen_d = pin_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b1;
    else         seen_q <= seen_d;
  end

  assign evt_o = tick_i & seen_q & ~pin_s;
endmodule

// File: rtl/dtu_count_byte.sv
module dtu_count_byte #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic         reload_en_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max;

  assign at_max = (cnt_q == MAXV);
  assign wrap_o = inc_i & at_max & ~we_i;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)                     cnt_d = wdata_i;
    else if (wrap_o && reload_en_i) cnt_d = reload_val_i;
    else if (inc_i)               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign q_o = cnt_q;
endmodule

// File: rtl/dtu_flag.sv
module dtu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (we_i)       flag_d = wdata_i;
    else if (set_i) flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign q_o = flag_q;
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_pin_i,
  input  logic             gate_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             flag_a_we_i,
  input  logic             flag_a_wdata_i,
  input  logic             flag_b_we_i,
  input  logic             flag_b_wdata_i,
  input  logic             ack_a_i,
  input  logic             ack_b_i,
  output logic [W-1:0]     lo_o,
  output logic [W-1:0]     hi_o,
  output logic             flag_a_o,
  output logic             flag_b_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // control register
  dtu_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i) ctl_d = dtu_ctl_t'(ctl_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // pin conditioning
  logic pin_evt;
  logic gate_s;

  dtu_fall_event #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .pin_i (cnt_pin_i),
    .tick_i(tick_i),
    .evt_o (pin_evt)
  );

  dtu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (gate_ni),
    .q_o   (gate_s)
  );

  // count enables
  logic mode_split;
  logic gate_ok;
  logic lo_src;
  logic inc_lo;
  logic inc_hi;
  logic lo_wrap;
  logic hi_wrap;

  assign mode_split = ctl_q.split;
  assign gate_ok    = ~ctl_q.gate | ~gate_s;
  assign lo_src     = ctl_q.src_ext ? pin_evt : tick_i;
  assign inc_lo     = ctl_q.run_a & gate_ok & lo_src;
  assign inc_hi     = mode_split & ctl_q.run_b & tick_i;

  logic [W-1:0] lo_q;
  logic [W-1:0] hi_q;

  dtu_count_byte #(.W(W)) u_lo (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .we_i        (lo_we_i),
    .wdata_i     (wdata_i),
    .inc_i       (inc_lo),
    .reload_en_i (~mode_split),
    .reload_val_i(hi_q),
    .q_o         (lo_q),
    .wrap_o      (lo_wrap)
  );

  dtu_count_byte #(.W(W)) u_hi (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .we_i        (hi_we_i),
    .wdata_i     (wdata_i),
    .inc_i       (inc_hi),
    .reload_en_i (1'b0),
    .reload_val_i('0),
    .q_o         (hi_q),
    .wrap_o      (hi_wrap)
  );

  dtu_flag u_flag_a (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (flag_a_we_i),
    .wdata_i(flag_a_wdata_i),
    .set_i  (lo_wrap),
    .clr_i  (ack_a_i),
    .q_o    (flag_a_o)
  );

  dtu_flag u_flag_b (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (flag_b_we_i),
    .wdata_i(flag_b_wdata_i),
    .set_i  (hi_wrap),
    .clr_i  (ack_b_i),
    .q_o    (flag_b_o)
  );

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         mode_split,
  input logic         run_b,
  input logic         inc_lo,
  input logic         lo_wrap,
  input logic         lo_we_i,
  input logic         hi_we_i,
  input logic [W-1:0] wdata_i,
  input logic         flag_a_we_i,
  input logic         flag_a_wdata_i,
  input logic         flag_b_we_i,
  input logic         ack_a_i,
  input logic [W-1:0] lo_o,
  input logic [W-1:0] hi_o,
  input logic         flag_a_o,
  input logic         flag_b_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  p_reload_load_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_split && inc_lo && lo_o == MAXV && !lo_we_i && !flag_a_we_i)
      |=> (lo_o == $past(hi_o)) && flag_a_o);

  p_hi_held_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_split && !hi_we_i) |=> $stable(hi_o));

  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_a_i && !flag_a_we_i && !lo_wrap) |=> !flag_a_o);

  p_split_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_split && inc_lo && lo_o == MAXV && !lo_we_i) |=> lo_o == '0);

  p_hi_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_split && !run_b && !hi_we_i) |=> $stable(hi_o));

  p_no_flag_b_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_split && !flag_b_we_i && !flag_b_o) |=> !flag_b_o);

  p_flag_write_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    flag_a_we_i |=> flag_a_o == $past(flag_a_wdata_i));

  p_byte_write_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    lo_we_i |=> lo_o == $past(wdata_i));
endmodule

bind dual_timer_unit dtu_checker #(.W(W)) u_dtu_checker (
  .clk_i         (clk_i),
  .rst_n         (rst_n),
  .mode_split    (mode_split),
  .run_b         (ctl_q.run_b),
  .inc_lo        (inc_lo),
  .lo_wrap       (lo_wrap),
  .lo_we_i       (lo_we_i),
  .hi_we_i       (hi_we_i),
  .wdata_i       (wdata_i),
  .flag_a_we_i   (flag_a_we_i),
  .flag_a_wdata_i(flag_a_wdata_i),
  .flag_b_we_i   (flag_b_we_i),
  .ack_a_i       (ack_a_i),
  .lo_o          (lo_o),
  .hi_o          (hi_o),
  .flag_a_o      (flag_a_o),
  .flag_b_o      (flag_b_o)
);

// File: tb/tb_dual_timer_unit.sv
module tb_dual_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, cnt_pin_i, gate_ni;
  logic       ctl_we_i;
  logic [4:0] ctl_wdata_i;
  logic       lo_we_i, hi_we_i;
  logic [7:0] wdata_i;
  logic       flag_a_we_i, flag_a_wdata_i, flag_b_we_i, flag_b_wdata_i;
  logic       ack_a_i, ack_b_i;
  logic [7:0] lo_o, hi_o;
  logic       flag_a_o, flag_b_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_timer_unit dut (.*);

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       fa;
    logic       fb;
    string      tag;
  } exp_t;

  exp_t  expq[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string phase    = "R11";

  // reference state, built from the requirements
  logic [7:0] m_lo, m_hi;
  logic       m_fa, m_fb;
  logic [4:0] m_ctl;
  logic       p1, p2, pseen, g1, g2;

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_fa = 0; m_fb = 0; m_ctl = 0;
    p1 = 1; p2 = 1; pseen = 1; g1 = 1; g2 = 1;
  endtask

  task automatic idle_inputs();
    ctl_we_i = 0; ctl_wdata_i = 0; lo_we_i = 0; hi_we_i = 0; wdata_i = 0;
    flag_a_we_i = 0; flag_a_wdata_i = 0; flag_b_we_i = 0; flag_b_wdata_i = 0;
    ack_a_i = 0; ack_b_i = 0;
  endtask

  // driver: called with inputs set, half a cycle after an edge
  task automatic step();
    logic       split, evt, gok, inc_l, inc_h, wl, wh;
    logic [7:0] nl, nh;
    exp_t       e;
    split = m_ctl[4];
    evt   = tick_i & pseen & ~p2;
    gok   = ~m_ctl[3] | ~g2;
    inc_l = m_ctl[0] & gok & (m_ctl[2] ? evt : tick_i);
    inc_h = split & m_ctl[1] & tick_i;
    wl    = inc_l & (m_lo == 8'hFF) & ~lo_we_i;
    wh    = inc_h & (m_hi == 8'hFF) & ~hi_we_i;
    if (lo_we_i)   nl = wdata_i;
    else if (wl)   nl = split ? 8'h00 : m_hi;
    else if (inc_l) nl = m_lo + 8'd1;
    else           nl = m_lo;
    if (hi_we_i)   nh = wdata_i;
    else if (inc_h) nh = m_hi + 8'd1;
    else           nh = m_hi;
    if (flag_a_we_i) m_fa = flag_a_wdata_i;
    else if (wl)     m_fa = 1'b1;
    else if (ack_a_i) m_fa = 1'b0;
    if (flag_b_we_i) m_fb = flag_b_wdata_i;
    else if (wh)     m_fb = 1'b1;
    else if (ack_b_i) m_fb = 1'b0;
    if (tick_i) pseen = p2;
    p2 = p1; p1 = cnt_pin_i;
    g2 = g1; g1 = gate_ni;
    if (ctl_we_i) m_ctl = ctl_wdata_i;
    m_lo = nl; m_hi = nh;
    e.lo = m_lo; e.hi = m_hi; e.fa = m_fa; e.fb = m_fb; e.tag = phase;
    expq.push_back(e);
    @(posedge clk_i);
    #(CLK_PERIOD/2);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(logic [4:0] v);
    ctl_we_i = 1; ctl_wdata_i = v; step(); ctl_we_i = 0;
  endtask

  task automatic wr_lo(logic [7:0] v);
    lo_we_i = 1; wdata_i = v; step(); lo_we_i = 0;
  endtask

  task automatic wr_hi(logic [7:0] v);
    hi_we_i = 1; wdata_i = v; step(); hi_we_i = 0;
  endtask

  // monitor: pops one expected item a quarter cycle after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_checks++;
        if (lo_o !== e.lo || hi_o !== e.hi || flag_a_o !== e.fa || flag_b_o !== e.fb) begin
          n_fail++;
          $display("FAIL %s: got lo=%02h hi=%02h fa=%0b fb=%0b, expected lo=%02h hi=%02h fa=%0b fb=%0b",
                   e.tag, lo_o, hi_o, flag_a_o, flag_b_o, e.lo, e.hi, e.fa, e.fb);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    tick_i = 1; cnt_pin_i = 1; gate_ni = 1;
    rst_ni = 0;
    model_reset();
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/2);
    rst_ni = 1;
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/2);

    phase = "R11"; steps(2);
    phase = "R12"; wr_hi(8'hFC); wr_lo(8'hFD); wr_ctl(5'b00001); steps(2);
    phase = "R1";  steps(6);
    phase = "R2";  wr_hi(8'h10); steps(8); steps(240);
    phase = "R3";  ack_a_i = 1; step(); ack_a_i = 0; steps(2);
    phase = "R5";  wr_ctl(5'b00000); steps(3);
    wr_ctl(5'b01001); steps(4);
    gate_ni = 0; steps(5);
    gate_ni = 1; steps(4);
    phase = "R4";  wr_lo(8'h00); wr_ctl(5'b00101); steps(3);
    cnt_pin_i = 0; steps(4); cnt_pin_i = 1; steps(4);
    cnt_pin_i = 0; steps(4); cnt_pin_i = 1; steps(4);
    tick_i = 0; cnt_pin_i = 0; steps(5); tick_i = 1; steps(3);
    cnt_pin_i = 1; steps(3);
    phase = "R6";  wr_lo(8'hF0); wr_hi(8'hFD); wr_ctl(5'b10001); steps(18);
    phase = "R7";  wr_ctl(5'b10011); steps(6);
    tick_i = 0; steps(3); tick_i = 1;
    wr_ctl(5'b11111); gate_ni = 1; steps(4);
    ack_b_i = 1; step(); ack_b_i = 0; steps(2);
    phase = "R8";  wr_hi(8'hFF); wr_ctl(5'b00011); steps(6);
    phase = "R9";  wr_ctl(5'b00001); wr_lo(8'hFE); step();
    flag_a_we_i = 1; flag_a_wdata_i = 0; step(); flag_a_we_i = 0; steps(2);
    wr_lo(8'hFF); ack_a_i = 1; step(); ack_a_i = 0; steps(2);
    flag_b_we_i = 1; flag_b_wdata_i = 1; step(); flag_b_we_i = 0; steps(2);
    flag_b_we_i = 1; flag_b_wdata_i = 0; step(); flag_b_we_i = 0; steps(1);
    phase = "R10"; ack_a_i = 1; step(); ack_a_i = 0;
    wr_lo(8'hFF); wr_lo(8'h55); steps(2);
    wr_lo(8'hFF); wr_lo(8'hFF); steps(2);

    @(posedge clk_i);
    #(CLK_PERIOD/2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule